// File: doc/BRIEF.md
# Iterative Multiply/Divide Engine with HI/LO Result Pair

This block is a sequential integer multiply and divide engine for a 32-bit processor datapath. It holds two architectural result registers, HI and LO. A one-cycle start strobe launches one of four operations on two operands: signed or unsigned multiply, or signed or unsigned divide. A multiply leaves the 64-bit product split across the pair, with the upper half in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI. No operation ever reports an overflow.

The work is done one bit per cycle. A multiply uses shift-and-add steps that accumulate into a 64-bit register pair. A divide uses restoring shift-and-subtract steps. Signed operands are first reduced to magnitudes, and the result is negated at the end when the operand signs require it. The pipeline stalls on `busy`. The contents of HI and LO are always visible on two read outputs, which serve as the move-from path. Two write strobes load either register from a data input, which serves as the move-to path. Those writes take effect only while the engine is not busy.

The controller has four states:

- `ST_IDLE` waits. It goes to `ST_SETUP` when start is high and otherwise stays put.
- `ST_SETUP` converts the captured operands to magnitudes, records the sign corrections and clears the accumulator. It always goes to `ST_RUN`.
- `ST_RUN` performs one iteration per cycle. After the last iteration it writes HI/LO and goes to `ST_DONE`.
- `ST_DONE` raises done for one cycle. It goes to `ST_SETUP` if start is high in that cycle, and otherwise returns to `ST_IDLE`.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, busy and done are low and both HI and LO read as zero.
- R2: Operation code 2'b00 (signed multiply) leaves the upper 32 bits of the two's-complement 64-bit product in HI and the lower 32 bits in LO.
- R3: Operation code 2'b01 (unsigned multiply) leaves the upper 32 bits of the unsigned 64-bit product in HI and the lower 32 bits in LO.
- R4: Operation code 2'b10 (signed divide) puts the quotient, truncated toward zero, in LO and the remainder, which carries the sign of the dividend, in HI. The most negative dividend divided by -1 yields 0x80000000 in LO and zero in HI, with no overflow indication.
- R5: Operation code 2'b11 (unsigned divide) puts the unsigned quotient in LO and the unsigned remainder in HI.
- R6: A start accepted while the engine is not busy raises busy on the next cycle. Busy then stays high for 33 cycles (one setup and 32 iterations). Done then pulses high for exactly one cycle, with busy low and the new HI/LO already visible. A new start may be accepted in the done cycle.
- R7: A divide by zero completes on the normal schedule with no trap. HI receives the dividend unchanged. LO receives 0xFFFFFFFF, except for a signed divide of a negative dividend, where LO receives 1.
- R8: HI and LO are readable at all times on their own outputs, and they change only when an operation completes or when a move-to write is accepted.
- R9: While not busy, a high wr_hi loads HI from wr_data on the next clock edge and a high wr_lo loads LO from wr_data on the next clock edge. The register not selected is left unchanged.
- R10: While busy, wr_hi and wr_lo are ignored. HI and LO keep their previous values until the operation completes.
- R11: A start strobe raised while busy is ignored. The running operation finishes on its original schedule with its original operands, and exactly one done pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, taken when not busy |
| op | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| wr_hi | input | 1 | Move-to-HI strobe |
| wr_lo | input | 1 | Move-to-LO strobe |
| wr_data | input | 32 | Data for move-to writes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi_rd | output | 32 | Current HI contents |
| lo_rd | output | 32 | Current LO contents |

## Verification
The bound checker watches the handshake on every cycle:

- an accepted start raises busy;
- done lasts one cycle, never coincides with busy and always follows a busy cycle;
- HI/LO hold still across consecutive busy cycles;
- a move-to write outside busy lands on the next edge.

The arithmetic itself cannot be shown by the checker and is left to the bench scenarios, which compare the values and the exact 33-cycle latency against an independent model. Those scenarios include:

- mixed-sign operands and the most negative operand;
- division by zero;
- start or move-to strobes raised during a run;
- back-to-back launches in the done cycle.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULS = 2'b00,
        OP_MULU = 2'b01,
        OP_DIVS = 2'b10,
        OP_DIVU = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RUN,
        ST_DONE
    } md_state_e;

endpackage

// File: rtl/muldiv_sign_prep.sv
module muldiv_sign_prep #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic            is_signed,
    output logic [XLEN-1:0] mag_a,
    output logic [XLEN-1:0] mag_b,
    output logic            neg_main,
    output logic            neg_rem
);
    localparam int NOPND = 2;

    logic [NOPND-1:0][XLEN-1:0] raw;
    logic [NOPND-1:0][XLEN-1:0] mag;
    logic [NOPND-1:0]           is_neg;

    assign raw[0] = opnd_a;
    assign raw[1] = opnd_b;

    // Each operand is reduced to its magnitude when the operation is signed
    for (genvar g = 0; g < NOPND; g++) begin : g_mag
        assign is_neg[g] = is_signed & raw[g][XLEN-1];
        assign mag[g]    = is_neg[g] ? (~raw[g] + 1'b1) : raw[g];
    end

    assign mag_a    = mag[0];
    assign mag_b    = mag[1];
    // product or quotient negative when signs differ; remainder follows dividend
    assign neg_main = is_neg[0] ^ is_neg[1];
    assign neg_rem  = is_neg[0];

endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
    parameter int XLEN = 32
) (
    input  logic            is_div,
    input  logic [XLEN-1:0] acc_hi,
    input  logic [XLEN-1:0] acc_lo,
    input  logic [XLEN-1:0] oper,
    output logic [XLEN-1:0] nxt_hi,
    output logic [XLEN-1:0] nxt_lo
);
    logic [XLEN:0]   add_sum;
    logic [XLEN:0]   shifted;
    logic [XLEN+1:0] trial;
    logic            borrow;

    always_comb begin
        // multiply: conditional add then shift the 64-bit pair right
        add_sum = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, oper} : {(XLEN+1){1'b0}});
        // divide: shift remainder left, try subtracting divisor
        shifted = {acc_hi, acc_lo[XLEN-1]};
        trial   = {1'b0, shifted} - {2'b00, oper};
        borrow  = trial[XLEN+1];

        if (is_div) begin
            nxt_hi = borrow ? shifted[XLEN-1:0] : trial[XLEN-1:0];
            nxt_lo = {acc_lo[XLEN-2:0], ~borrow};
        end else begin
            nxt_hi = add_sum[XLEN:1];
            nxt_lo = {add_sum[0], acc_lo[XLEN-1:1]};
        end
    end

endmodule

// File: rtl/muldiv_sign_fix.sv
module muldiv_sign_fix #(
    parameter int XLEN = 32
) (
    input  logic            is_div,
    input  logic            neg_main,
    input  logic            neg_rem,
    input  logic [XLEN-1:0] raw_hi,
    input  logic [XLEN-1:0] raw_lo,
    output logic [XLEN-1:0] res_hi,
    output logic [XLEN-1:0] res_lo
);
    localparam int DW = 2 * XLEN;

    logic [DW-1:0] prod;

    always_comb begin
        prod = {raw_hi, raw_lo};
        if (neg_main) begin
            prod = ~prod + 1'b1;
        end
        if (is_div) begin
            res_lo = neg_main ? (~raw_lo + 1'b1) : raw_lo;
            res_hi = neg_rem  ? (~raw_hi + 1'b1) : raw_hi;
        end else begin
            res_hi = prod[DW-1:XLEN];
            res_lo = prod[XLEN-1:0];
        end
    end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic            wr_hi,
    input  logic            wr_lo,
    input  logic [XLEN-1:0] wr_data,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] hi_rd,
    output logic [XLEN-1:0] lo_rd
);
    localparam int NITER = XLEN;
    localparam int CNT_W = $clog2(NITER);
    localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(NITER - 1);

    md_state_e       state, nxt_state;
    md_op_e          op_q;
    logic [XLEN-1:0] a_q, b_q;
    logic [XLEN-1:0] oper_q;
    logic [XLEN-1:0] acc_hi, acc_lo;
    logic [XLEN-1:0] hi_q, lo_q;
    logic [CNT_W-1:0] iter_q;
    logic            neg_main_q, neg_rem_q;
    logic            accept;
    logic            last_it;
    logic            op_is_div, op_is_signed;

    logic [XLEN-1:0] mag_a, mag_b;
    logic            neg_main_c, neg_rem_c;
    logic [XLEN-1:0] step_hi, step_lo;
    logic [XLEN-1:0] fix_hi, fix_lo;

    assign op_is_div    = op_q[1];
    assign op_is_signed = ~op_q[0];
    assign last_it      = (iter_q == LAST_IT);

    muldiv_sign_prep #(.XLEN(XLEN)) u_prep (
        .opnd_a    (a_q),
        .opnd_b    (b_q),
        .is_signed (op_is_signed),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .neg_main  (neg_main_c),
        .neg_rem   (neg_rem_c)
    );

    muldiv_step #(.XLEN(XLEN)) u_step (
        .is_div (op_is_div),
        .acc_hi (acc_hi),
        .acc_lo (acc_lo),
        .oper   (oper_q),
        .nxt_hi (step_hi),
        .nxt_lo (step_lo)
    );

    muldiv_sign_fix #(.XLEN(XLEN)) u_fix (
        .is_div   (op_is_div),
        .neg_main (neg_main_q),
        .neg_rem  (neg_rem_q),
        .raw_hi   (step_hi),
        .raw_lo   (step_lo),
        .res_hi   (fix_hi),
        .res_lo   (fix_lo)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    // Next state
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:  nxt_state = start ? ST_SETUP : ST_IDLE;
            ST_SETUP: nxt_state = ST_RUN;
            ST_RUN:   nxt_state = last_it ? ST_DONE : ST_RUN;
            ST_DONE:  nxt_state = start ? ST_SETUP : ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_SETUP: busy = 1'b1;
            ST_RUN:   busy = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    assign accept = start & ~busy;

    // Operand capture, setup and iteration datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_MULS;
            a_q        <= '0;
            b_q        <= '0;
            oper_q     <= '0;
            acc_hi     <= '0;
            acc_lo     <= '0;
            iter_q     <= '0;
            neg_main_q <= 1'b0;
            neg_rem_q  <= 1'b0;
        end else begin
            if (accept) begin
                op_q <= md_op_e'(op);
                a_q  <= src_a;
                b_q  <= src_b;
            end
            if (state == ST_SETUP) begin
                acc_hi     <= '0;
                acc_lo     <= mag_a;
                oper_q     <= mag_b;
                neg_main_q <= neg_main_c;
                neg_rem_q  <= neg_rem_c;
                iter_q     <= '0;
            end else if (state == ST_RUN) begin
                acc_hi <= step_hi;
                acc_lo <= step_lo;
                iter_q <= iter_q + 1'b1;
            end
        end
    end

    // Architectural HI/LO
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (state == ST_RUN && last_it) begin
            hi_q <= fix_hi;
            lo_q <= fix_lo;
        end else if (!busy) begin
            if (wr_hi) hi_q <= wr_data;
            if (wr_lo) lo_q <= wr_data;
        end
    end

    assign hi_rd = hi_q;
    assign lo_rd = lo_q;

endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            wr_hi,
    input logic            wr_lo,
    input logic [XLEN-1:0] wr_data,
    input logic [XLEN-1:0] hi_rd,
    input logic [XLEN-1:0] lo_rd
);

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy) else $error("start not taken"); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R6

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done with busy"); // R6

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)) else $error("done without run"); // R6

    AST_HILO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(hi_rd) && $stable(lo_rd)))
        else $error("HI/LO moved mid-run"); // R10

    AST_MOVE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_hi) |=> (hi_rd == $past(wr_data))) else $error("HI write lost"); // R9

    AST_MOVE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_lo) |=> (lo_rd == $past(wr_data))) else $error("LO write lost"); // R9

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wr_data (wr_data),
    .hi_rd   (hi_rd),
    .lo_rd   (lo_rd)
);

// File: tb/muldiv_hilo_test.sv
`timescale 1ns/1ps
module muldiv_hilo_test;

    localparam int LATENCY = 33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        wr_hi = 1'b0;
    logic        wr_lo = 1'b0;
    logic [31:0] wr_data = '0;
    logic        busy, done;
    logic [31:0] hi_rd, lo_rd;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [63:0] exp_q[$];
    int          t0_q[$];
    string       tag_q[$];

    muldiv_hilo uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .busy(busy), .done(done),
        .hi_rd(hi_rd), .lo_rd(lo_rd)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    // Reference model written from the requirements
    function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a,
                                          input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] res;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        res = '0;
        case (o)
            2'b00: res = sa * sb;
            2'b01: res = {32'd0, a} * {32'd0, b};
            2'b10: begin
                if (b == 0) res = {a, (a[31] ? 32'd1 : 32'hFFFF_FFFF)};
                else begin
                    q = sa / sb;
                    r = sa % sb;
                    res = {r[31:0], q[31:0]};
                end
            end
            default: begin
                if (b == 0) res = {a, 32'hFFFF_FFFF};
                else res = {a % b, a / b};
            end
        endcase
        return res;
    endfunction

    // Monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R11 unexpected done actual=1 expected=0");
            end else begin
                logic [63:0] e;
                int t0;
                string tg;
                e  = exp_q.pop_front();
                t0 = t0_q.pop_front();
                tg = tag_q.pop_front();
                chk({tg, " HI"}, hi_rd, e[63:32]);
                chk({tg, " LO"}, lo_rd, e[31:0]);
                chk("R6 latency", 32'(cyc - t0), 32'(LATENCY));
                chk("R6 busy low at done", 32'(busy), 32'd0);
            end
        end
    end

    // Driver: launch without waiting for completion; caller sits at a negedge
    task automatic launch(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                          input string tag);
        op = o; src_a = a; src_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 busy after start", 32'(busy), 32'd1);
        exp_q.push_back(model(o, a, b));
        t0_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input string tag);
        launch(o, a, b, tag);
        wait_done();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin : stim
        logic [31:0] hi0, lo0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 HI reset", hi_rd, 32'd0);
        chk("R1 LO reset", lo_rd, 32'd0);
        chk("R1 busy reset", 32'(busy), 32'd0);
        chk("R1 done reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 move-to writes while idle
        wr_hi = 1'b1; wr_data = 32'h1234_5678;
        @(negedge clk);
        wr_hi = 1'b0;
        chk("R9 mthi HI", hi_rd, 32'h1234_5678);
        chk("R9 mthi LO untouched", lo_rd, 32'd0);
        wr_lo = 1'b1; wr_data = 32'hCAFE_0001;
        @(negedge clk);
        wr_lo = 1'b0;
        chk("R9 mtlo LO", lo_rd, 32'hCAFE_0001);
        chk("R9 mtlo HI untouched", hi_rd, 32'h1234_5678);
        // R8 values hold with no activity
        repeat (3) @(negedge clk);
        chk("R8 HI held", hi_rd, 32'h1234_5678);
        chk("R8 LO held", lo_rd, 32'hCAFE_0001);

        // R2 signed multiply
        issue(2'b00, 32'd7, -32'sd3, "R2 7*-3");
        issue(2'b00, -32'sd5, -32'sd9, "R2 -5*-9");
        issue(2'b00, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
        issue(2'b00, 32'h1234_5678, 32'hFFFF_FFFF, "R2 x*-1");
        // R3 unsigned multiply
        issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 max*max");
        issue(2'b01, 32'h8000_0000, 32'd2, "R3 carry into HI");
        issue(2'b01, 32'd12345, 32'd6789, "R3 small");
        // R4 signed divide
        issue(2'b10, -32'sd7, 32'd2, "R4 -7/2");
        issue(2'b10, 32'd7, -32'sd2, "R4 7/-2");
        issue(2'b10, -32'sd7, -32'sd2, "R4 -7/-2");
        issue(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R4 min/-1");
        issue(2'b10, 32'd100, 32'd7, "R4 100/7");
        // R5 unsigned divide
        issue(2'b11, 32'hFFFF_FFFF, 32'd3, "R5 max/3");
        issue(2'b11, 32'd5, 32'd9, "R5 5/9");
        issue(2'b11, 32'h8000_0000, 32'h8000_0000, "R5 equal");
        // R7 divide by zero
        issue(2'b10, 32'd5, 32'd0, "R7 signed 5/0");
        issue(2'b10, -32'sd5, 32'd0, "R7 signed -5/0");
        issue(2'b11, 32'hDEAD_BEEF, 32'd0, "R7 unsigned x/0");

        // R10 move-to writes while busy are ignored
        @(negedge clk);
        hi0 = hi_rd; lo0 = lo_rd;
        launch(2'b01, 32'd1000, 32'd1000, "R10 run");
        repeat (3) @(negedge clk);
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hAAAA_5555;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b0;
        chk("R10 HI unchanged while busy", hi_rd, hi0);
        chk("R10 LO unchanged while busy", lo_rd, lo0);
        wait_done();

        // R11 start while busy is ignored
        @(negedge clk);
        launch(2'b11, 32'd1000, 32'd10, "R11 run");
        repeat (5) @(negedge clk);
        op = 2'b00; src_a = 32'd3; src_b = 32'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (40) @(negedge clk);
        chk("R11 queue drained", 32'(exp_q.size()), 32'd0);

        summary();
        $finish;
    end

endmodule